// File: doc/BRIEF.md
# Dual-Channel UART Register Front End

This block is the host-facing register layer of a two-channel UART. A byte-wide host bus reads and writes a small window of registers per channel. The block turns those accesses into mode-field signals, enable flags, a break level and one-cycle strobes. These outputs drive a separate transmitter/receiver core. That core also supplies the live status flags, error events and received characters that come back through the status and data registers.

The three mode registers of a channel share one address. An internal pointer picks which one a write reaches, and it moves forward after each write. The command register carries four enable/disable bits and a 4-bit command code. The code can move the pointer, reset a direction, clear the sticky error bits, clear the break-change flag in the core, or start and stop a break.

Channel c occupies bus addresses 8*c+0 to 8*c+3. Address bit 2 set is an unused hole. Within a channel, offset 0 is mode, offset 1 is status (read) / clock select (write), offset 2 is command (write) and offset 3 is receive data (read) / transmit data (write).

Top module: `uart_regfront`

## Requirements
- R1: Address bit 3 selects the channel and bits 1:0 the offset. An access with address bit 2 set changes no state, raises no strobe and reads back 0x00.
- R2: After reset the mode pointer selects MR1. A write to offset 0 stores into the selected register and moves the pointer forward: MR0 to MR1, then MR1 to MR2. At MR2 it stays, so further writes overwrite MR2. A read of offset 0 returns the selected register and does not move the pointer.
- R3: Command code (bits 7:4) 0x1 sets the pointer to MR1 and code 0xB sets it to MR0.
- R4: Per-channel mode outputs are registered copies of the mode fields. Character length is MR1[1:0] and parity select is MR1[4:2] (000 even, 001 odd, 100 none). Stop select is MR2[3:0] (0x7 one, 0xF two). Deep-FIFO enable is MR0[3], the half-level transmit threshold is MR0[4] and the extended baud select is MR0[2:0].
- R5: Command bit 0 enables RX, bit 1 disables RX, bit 2 enables TX and bit 3 disables TX. When the enable and disable bits for one direction are both set, the direction ends disabled.
- R6: Code 0x2 (RX reset) and code 0x3 (TX reset) each give a one-cycle strobe in the cycle after the write. Each also clears that direction's enable, even if the same write sets the enable bit.
- R7: Code 0x6 raises the break level and code 0x7 lowers it. Code 0x5 gives a one-cycle break-change-clear strobe.
- R8: A read of offset 1 returns the status byte: bit 0 RX ready, 1 RX FIFO full, 2 TX ready, 3 TX empty, 4 overrun, 5 parity error, 6 framing error, 7 break received. Bits 3:0 are the live core flags. Bits 7:4 are sticky and are set by the error-event inputs, whose bits 0 to 3 map to status bits 4 to 7.
- R9: Code 0x4 clears the sticky error bits. An error event arriving in the same cycle as this command is kept.
- R10: A write to offset 1 loads the 8-bit clock select. A write to offset 3 gives a one-cycle transmit push strobe with the byte. A read of offset 3 returns the core's receive character and gives a one-cycle pop strobe.
- R11: Read data is registered. It appears in the cycle after the read and is 0x00 in any cycle after no read. Reset clears every register, flag and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host address |
| bus_wr | input | 1 | Host write |
| bus_rd | input | 1 | Host read |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| st_rx_ready | input | 2 | Core: receive character waiting, per channel |
| st_rx_full | input | 2 | Core: receive FIFO full, per channel |
| st_tx_ready | input | 2 | Core: transmit can accept, per channel |
| st_tx_empty | input | 2 | Core: transmitter idle, per channel |
| err_evt | input | 8 | Core error pulses, 4 per channel (overrun, parity, framing, break) |
| rx_char | input | 16 | Core receive character, 8 per channel |
| char_len | output | 4 | Character length select, 2 per channel |
| parity_sel | output | 6 | Parity select, 3 per channel |
| stop_sel | output | 8 | Stop length select, 4 per channel |
| fifo_deep | output | 2 | Deep FIFO enable |
| tx_half_thr | output | 2 | Half-level transmit threshold |
| baud_ext | output | 6 | Extended baud select, 3 per channel |
| clk_sel | output | 16 | Clock select byte, 8 per channel |
| rx_en | output | 2 | Receiver enabled |
| tx_en | output | 2 | Transmitter enabled |
| rx_rst_stb | output | 2 | Receiver reset strobe |
| tx_rst_stb | output | 2 | Transmitter reset strobe |
| bchg_clr_stb | output | 2 | Break-change flag clear strobe |
| break_on | output | 2 | Send break level |
| tx_push | output | 2 | Transmit byte push strobe |
| tx_char | output | 16 | Transmit byte, 8 per channel |
| rx_pop | output | 2 | Receive character pop strobe |

## Verification
Two of this block's functions can fall in the same cycle: an error event from the core setting a sticky status bit, and the error-reset command clearing those bits. The bench provokes the overlap by pulsing one error input in the very cycle that it writes code 0x4, while an older error bit is already set. It then reads status and expects the older bit gone and the new one present. The same idea is applied to commands that set the enable and disable bits together, and to reset codes combined with an enable bit. A behavioural model compares every output on every clock, including a long stretch of random traffic.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } mode_ptr_e;

  localparam logic [3:0] CMD_PTR_MR1  = 4'h1;
  localparam logic [3:0] CMD_RX_RST   = 4'h2;
  localparam logic [3:0] CMD_TX_RST   = 4'h3;
  localparam logic [3:0] CMD_ERR_CLR  = 4'h4;
  localparam logic [3:0] CMD_BCHG_CLR = 4'h5;
  localparam logic [3:0] CMD_BRK_ON   = 4'h6;
  localparam logic [3:0] CMD_BRK_OFF  = 4'h7;
  localparam logic [3:0] CMD_PTR_MR0  = 4'hB;

  localparam logic [1:0] OFF_MODE = 2'd0;
  localparam logic [1:0] OFF_CLK  = 2'd1;
  localparam logic [1:0] OFF_CMD  = 2'd2;
  localparam logic [1:0] OFF_DATA = 2'd3;
endpackage

// File: rtl/uart_rf_modeptr.sv
module uart_rf_modeptr
  import uart_rf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  logic [DW-1:0] wdata,
  input  logic          go_mr0,
  input  logic          go_mr1,
  output logic [DW-1:0] mr0,
  output logic [DW-1:0] mr1,
  output logic [DW-1:0] mr2,
  output mode_ptr_e     ptr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= PTR_MR1;
      mr0 <= '0;
      mr1 <= '0;
      mr2 <= '0;
    end else if (go_mr0) begin
      ptr <= PTR_MR0;
    end else if (go_mr1) begin
      ptr <= PTR_MR1;
    end else if (mode_we) begin
      case (ptr)
        PTR_MR0: begin mr0 <= wdata; ptr <= PTR_MR1; end
        PTR_MR1: begin mr1 <= wdata; ptr <= PTR_MR2; end
        default: begin mr2 <= wdata; ptr <= PTR_MR2; end
      endcase
    end
  end

  assert_ptr_adv_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !go_mr0 && !go_mr1 && ptr == PTR_MR0) |=> (ptr == PTR_MR1));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_we && !go_mr0 && !go_mr1 && ptr == PTR_MR2) |=> (ptr == PTR_MR2 && mr2 == $past(wdata)));

  assert_ptr_cmd_R3: assert property (@(posedge clk) disable iff (rst)
    go_mr0 |=> (ptr == PTR_MR0));

endmodule

// File: rtl/uart_rf_chan.sv
module uart_rf_chan
  import uart_rf_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NERR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            rd,
  input  logic [1:0]      off,
  input  logic [DW-1:0]   wdata,
  input  logic            rx_ready,
  input  logic            rx_full,
  input  logic            tx_ready,
  input  logic            tx_empty,
  input  logic [NERR-1:0] err_evt,
  input  logic [DW-1:0]   rx_char,
  output logic [DW-1:0]   rd_byte,
  output logic [1:0]      char_len,
  output logic [2:0]      parity_sel,
  output logic [3:0]      stop_sel,
  output logic            fifo_deep,
  output logic            tx_half_thr,
  output logic [2:0]      baud_ext,
  output logic [DW-1:0]   clk_sel,
  output logic            rx_en,
  output logic            tx_en,
  output logic            rx_rst_stb,
  output logic            tx_rst_stb,
  output logic            bchg_clr_stb,
  output logic            break_on,
  output logic            tx_push,
  output logic [DW-1:0]   tx_char,
  output logic            rx_pop
);

  logic [DW-1:0]   mr0, mr1, mr2;
  mode_ptr_e       ptr;
  logic [NERR-1:0] err_q;
  logic            mode_we, cmd_we;
  logic [3:0]      code;

  assign mode_we = wr && (off == OFF_MODE);
  assign cmd_we  = wr && (off == OFF_CMD);
  assign code    = wdata[7:4];

  uart_rf_modeptr #(.DW(DW)) u_modes (
    .clk    (clk),
    .rst    (rst),
    .mode_we(mode_we),
    .wdata  (wdata),
    .go_mr0 (cmd_we && code == CMD_PTR_MR0),
    .go_mr1 (cmd_we && code == CMD_PTR_MR1),
    .mr0    (mr0),
    .mr1    (mr1),
    .mr2    (mr2),
    .ptr    (ptr)
  );

  assign char_len    = mr1[1:0];
  assign parity_sel  = mr1[4:2];
  assign stop_sel    = mr2[3:0];
  assign fifo_deep   = mr0[3];
  assign tx_half_thr = mr0[4];
  assign baud_ext    = mr0[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sel      <= '0;
      rx_en        <= 1'b0;
      tx_en        <= 1'b0;
      rx_rst_stb   <= 1'b0;
      tx_rst_stb   <= 1'b0;
      bchg_clr_stb <= 1'b0;
      break_on     <= 1'b0;
      tx_push      <= 1'b0;
      tx_char      <= '0;
      rx_pop       <= 1'b0;
      err_q        <= '0;
    end else begin
      rx_rst_stb   <= cmd_we && code == CMD_RX_RST;
      tx_rst_stb   <= cmd_we && code == CMD_TX_RST;
      bchg_clr_stb <= cmd_we && code == CMD_BCHG_CLR;
      tx_push      <= wr && off == OFF_DATA;
      rx_pop       <= rd && off == OFF_DATA;
      if (wr && off == OFF_DATA) tx_char <= wdata;
      if (wr && off == OFF_CLK)  clk_sel <= wdata;
      err_q <= (err_q & ~{NERR{cmd_we && code == CMD_ERR_CLR}}) | err_evt;
      if (cmd_we) begin
        if (code == CMD_RX_RST || wdata[1]) rx_en <= 1'b0;
        else if (wdata[0])                  rx_en <= 1'b1;
        if (code == CMD_TX_RST || wdata[3]) tx_en <= 1'b0;
        else if (wdata[2])                  tx_en <= 1'b1;
        if (code == CMD_BRK_ON)       break_on <= 1'b1;
        else if (code == CMD_BRK_OFF) break_on <= 1'b0;
      end
    end
  end

  always_comb begin
    case (off)
      OFF_MODE: begin
        case (ptr)
          PTR_MR0: rd_byte = mr0;
          PTR_MR1: rd_byte = mr1;
          default: rd_byte = mr2;
        endcase
      end
      OFF_CLK:  rd_byte = {err_q, tx_empty, tx_ready, rx_full, rx_ready};
      OFF_DATA: rd_byte = rx_char;
      default:  rd_byte = '0;
    endcase
  end

  assert_dis_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wdata[1]) |=> !rx_en);

  assert_tx_on_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && wdata[2] && !wdata[3] && code != CMD_TX_RST) |=> tx_en);

  assert_rst_clr_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == CMD_TX_RST) |=> (tx_rst_stb && !tx_en));

  assert_stb_single_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_rst_stb, tx_rst_stb, bchg_clr_stb}));

  assert_brk_on_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == CMD_BRK_ON) |=> break_on);

  assert_err_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |=> ((err_q & $past(err_evt)) == $past(err_evt)));

  assert_err_clr_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == CMD_ERR_CLR && err_evt == '0) |=> (err_q == '0));

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int DW   = 8,
  parameter int NERR = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    st_rx_ready,
  input  logic [NCH-1:0]    st_rx_full,
  input  logic [NCH-1:0]    st_tx_ready,
  input  logic [NCH-1:0]    st_tx_empty,
  input  logic [NCH*NERR-1:0] err_evt,
  input  logic [NCH*DW-1:0] rx_char,
  output logic [NCH*2-1:0]  char_len,
  output logic [NCH*3-1:0]  parity_sel,
  output logic [NCH*4-1:0]  stop_sel,
  output logic [NCH-1:0]    fifo_deep,
  output logic [NCH-1:0]    tx_half_thr,
  output logic [NCH*3-1:0]  baud_ext,
  output logic [NCH*DW-1:0] clk_sel,
  output logic [NCH-1:0]    rx_en,
  output logic [NCH-1:0]    tx_en,
  output logic [NCH-1:0]    rx_rst_stb,
  output logic [NCH-1:0]    tx_rst_stb,
  output logic [NCH-1:0]    bchg_clr_stb,
  output logic [NCH-1:0]    break_on,
  output logic [NCH-1:0]    tx_push,
  output logic [NCH*DW-1:0] tx_char,
  output logic [NCH-1:0]    rx_pop
);

  logic [NCH-1:0] sel;
  logic [DW-1:0]  rd_byte [NCH];
  logic [DW-1:0]  rd_mux;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sel[g] = !bus_addr[2] && (bus_addr[AW-1:3] == CHW'(g));

    uart_rf_chan #(.DW(DW), .NERR(NERR)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .wr          (bus_wr && sel[g]),
      .rd          (bus_rd && sel[g]),
      .off         (bus_addr[1:0]),
      .wdata       (bus_wdata),
      .rx_ready    (st_rx_ready[g]),
      .rx_full     (st_rx_full[g]),
      .tx_ready    (st_tx_ready[g]),
      .tx_empty    (st_tx_empty[g]),
      .err_evt     (err_evt[g*NERR +: NERR]),
      .rx_char     (rx_char[g*DW +: DW]),
      .rd_byte     (rd_byte[g]),
      .char_len    (char_len[g*2 +: 2]),
      .parity_sel  (parity_sel[g*3 +: 3]),
      .stop_sel    (stop_sel[g*4 +: 4]),
      .fifo_deep   (fifo_deep[g]),
      .tx_half_thr (tx_half_thr[g]),
      .baud_ext    (baud_ext[g*3 +: 3]),
      .clk_sel     (clk_sel[g*DW +: DW]),
      .rx_en       (rx_en[g]),
      .tx_en       (tx_en[g]),
      .rx_rst_stb  (rx_rst_stb[g]),
      .tx_rst_stb  (tx_rst_stb[g]),
      .bchg_clr_stb(bchg_clr_stb[g]),
      .break_on    (break_on[g]),
      .tx_push     (tx_push[g]),
      .tx_char     (tx_char[g*DW +: DW]),
      .rx_pop      (rx_pop[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel[i]) rd_mux = rd_mux | rd_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  assert_hole_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr[2] && (bus_wr || bus_rd)) |=> (bus_rdata == '0 && tx_push == '0 && rx_pop == '0));

endmodule

// File: tb/uart_regfront_test.sv
module uart_regfront_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  s_rxr = '0, s_rxf = '0, s_txr = '0, s_txe = '0;
  logic [7:0]  ev = '0;
  logic [15:0] rxc = '0;
  logic [3:0]  char_len;
  logic [5:0]  parity_sel, baud_ext;
  logic [7:0]  stop_sel;
  logic [1:0]  fifo_deep, tx_half_thr, rx_en, tx_en, rx_rst_stb, tx_rst_stb;
  logic [1:0]  bchg_clr_stb, break_on, tx_push, rx_pop;
  logic [15:0] clk_sel, tx_char;

  always #5 clk = ~clk;

  uart_regfront uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .st_rx_ready(s_rxr), .st_rx_full(s_rxf), .st_tx_ready(s_txr), .st_tx_empty(s_txe),
    .err_evt(ev), .rx_char(rxc),
    .char_len(char_len), .parity_sel(parity_sel), .stop_sel(stop_sel),
    .fifo_deep(fifo_deep), .tx_half_thr(tx_half_thr), .baud_ext(baud_ext),
    .clk_sel(clk_sel), .rx_en(rx_en), .tx_en(tx_en), .rx_rst_stb(rx_rst_stb),
    .tx_rst_stb(tx_rst_stb), .bchg_clr_stb(bchg_clr_stb), .break_on(break_on),
    .tx_push(tx_push), .tx_char(tx_char), .rx_pop(rx_pop)
  );

  // behavioural reference model
  logic [7:0] m_mr [2][3];
  int         m_ptr [2];
  logic [7:0] m_clk [2], m_txc [2];
  logic [3:0] m_err [2];
  logic [1:0] m_rxen, m_txen, m_rrs, m_trs, m_bcl, m_brk, m_push, m_pop;
  logic [7:0] m_rdata;

  int n_chk = 0, n_fail = 0;
  bit armed = 0, done = 0;
  string cur_tag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 3; k++) m_mr[c][k] = '0;
        m_ptr[c] = 1; m_clk[c] = '0; m_txc[c] = '0; m_err[c] = '0;
      end
      m_rxen = '0; m_txen = '0; m_rrs = '0; m_trs = '0; m_bcl = '0;
      m_brk = '0; m_push = '0; m_pop = '0; m_rdata = '0;
    end else begin
      int ch, off;
      bit hit;
      logic [3:0] code;
      ch = int'(addr[3]); off = int'(addr[1:0]); hit = !addr[2];
      code = wdata[7:4];
      m_rdata = '0;
      if (rd && hit) begin
        case (off)
          0: m_rdata = m_mr[ch][m_ptr[ch]];
          1: m_rdata = {m_err[ch], s_txe[ch], s_txr[ch], s_rxf[ch], s_rxr[ch]};
          3: m_rdata = rxc[ch*8 +: 8];
          default: m_rdata = '0;
        endcase
      end
      m_rrs = '0; m_trs = '0; m_bcl = '0; m_push = '0; m_pop = '0;
      for (int c = 0; c < 2; c++) begin
        bit clr;
        clr = wr && hit && ch == c && off == 2 && code == 4'h4;
        m_err[c] = (clr ? 4'h0 : m_err[c]) | ev[c*4 +: 4];
      end
      if (rd && hit && off == 3) m_pop[ch] = 1'b1;
      if (wr && hit) begin
        case (off)
          0: begin
            m_mr[ch][m_ptr[ch]] = wdata;
            if (m_ptr[ch] < 2) m_ptr[ch] = m_ptr[ch] + 1;
          end
          1: m_clk[ch] = wdata;
          2: begin
            if (code == 4'h1) m_ptr[ch] = 1;
            if (code == 4'hB) m_ptr[ch] = 0;
            if (wdata[1] || code == 4'h2) m_rxen[ch] = 1'b0;
            else if (wdata[0]) m_rxen[ch] = 1'b1;
            if (wdata[3] || code == 4'h3) m_txen[ch] = 1'b0;
            else if (wdata[2]) m_txen[ch] = 1'b1;
            if (code == 4'h2) m_rrs[ch] = 1'b1;
            if (code == 4'h3) m_trs[ch] = 1'b1;
            if (code == 4'h5) m_bcl[ch] = 1'b1;
            if (code == 4'h6) m_brk[ch] = 1'b1;
            if (code == 4'h7) m_brk[ch] = 1'b0;
          end
          default: begin m_push[ch] = 1'b1; m_txc[ch] = wdata; end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(cur_tag, 32'(rdata), 32'(m_rdata));
      chk("R4 char_len", 32'(char_len), 32'({m_mr[1][1][1:0], m_mr[0][1][1:0]}));
      chk("R4 parity", 32'(parity_sel), 32'({m_mr[1][1][4:2], m_mr[0][1][4:2]}));
      chk("R4 stop", 32'(stop_sel), 32'({m_mr[1][2][3:0], m_mr[0][2][3:0]}));
      chk("R4 mr0 fields", 32'({fifo_deep, tx_half_thr, baud_ext}),
          32'({m_mr[1][0][3], m_mr[0][0][3], m_mr[1][0][4], m_mr[0][0][4],
               m_mr[1][0][2:0], m_mr[0][0][2:0]}));
      chk("R5 enables", 32'({rx_en, tx_en}), 32'({m_rxen, m_txen}));
      chk("R6 reset strobes", 32'({rx_rst_stb, tx_rst_stb}), 32'({m_rrs, m_trs}));
      chk("R7 break", 32'({break_on, bchg_clr_stb}), 32'({m_brk, m_bcl}));
      chk("R10 clk_sel", 32'(clk_sel), 32'({m_clk[1], m_clk[0]}));
      chk("R10 tx path", 32'({tx_push, tx_char}), 32'({m_push, m_txc[1], m_txc[0]}));
      chk("R10 rx_pop", 32'(rx_pop), 32'(m_pop));
    end
  end

  task automatic step(input logic [3:0] a, input logic w, input logic r,
                      input logic [7:0] d, input logic [7:0] e);
    addr = a; wr = w; rd = r; wdata = d; ev = e;
    @(negedge clk); #1;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    step(a, 1'b1, 1'b0, d, 8'h00);
  endtask

  task automatic rreg(input logic [3:0] a);
    step(a, 1'b0, 1'b1, 8'h00, 8'h00);
  endtask

  task automatic idle();
    step(4'h0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; rst = 1'b0;
    armed = 1;
    cur_tag = "R11 reset state";
    idle(); idle();
    // R2: default pointer at MR1, then MR2, then stays
    cur_tag = "R2 pointer";
    rreg(4'h0);
    wreg(4'h0, 8'h13);
    wreg(4'h0, 8'h0F);
    wreg(4'h0, 8'h07);
    rreg(4'h0); rreg(4'h0);
    // R3: pointer commands
    cur_tag = "R3 pointer cmd";
    wreg(4'h2, 8'hB0);
    rreg(4'h0);
    wreg(4'h0, 8'h19);
    wreg(4'h0, 8'h04);
    wreg(4'h2, 8'hB0);
    wreg(4'h0, 8'h15);
    wreg(4'h2, 8'h10);
    rreg(4'h0);
    // channel 1 and the hole
    cur_tag = "R1 channel select";
    wreg(4'h8, 8'h02);
    wreg(4'h8, 8'h0F);
    rreg(4'h8);
    rreg(4'h0);
    cur_tag = "R1 hole";
    wreg(4'h4, 8'hFF);
    wreg(4'h6, 8'h05);
    wreg(4'h7, 8'hAA);
    rreg(4'h5); rreg(4'h7); rreg(4'h4);
    // R5 enable / disable priority
    cur_tag = "R5 enables";
    wreg(4'h2, 8'h05);
    wreg(4'h2, 8'h03);
    wreg(4'h2, 8'h0C);
    wreg(4'hA, 8'h05);
    wreg(4'h2, 8'h05);
    // R6 reset commands clear enables
    cur_tag = "R6 reset cmds";
    wreg(4'h2, 8'h21);
    wreg(4'h2, 8'h34);
    wreg(4'hA, 8'h20);
    // R7 break
    cur_tag = "R7 break";
    wreg(4'h2, 8'h60);
    wreg(4'h2, 8'h50);
    wreg(4'h2, 8'h70);
    wreg(4'hA, 8'h60);
    // R8 status and sticky errors
    cur_tag = "R8 status";
    s_rxr = 2'b01; s_rxf = 2'b10; s_txr = 2'b11; s_txe = 2'b01;
    rreg(4'h1); rreg(4'h9);
    step(4'h0, 1'b0, 1'b0, 8'h00, 8'h25);
    rreg(4'h1); rreg(4'h9);
    // R9 clear against simultaneous event
    cur_tag = "R9 err clear";
    step(4'h2, 1'b1, 1'b0, 8'h40, 8'h08);
    rreg(4'h1);
    wreg(4'h2, 8'h40);
    rreg(4'h1); rreg(4'h9);
    // R10 clock select and data path
    cur_tag = "R10 data";
    rxc = 16'hC35A;
    wreg(4'h1, 8'hBB);
    wreg(4'h9, 8'h44);
    wreg(4'h3, 8'h5A);
    rreg(4'h3); rreg(4'hB);
    idle();
    // mixed random traffic
    cur_tag = "R8 mixed";
    for (int i = 0; i < 400; i++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [1:0] op;
      a = 4'($urandom);
      d = 8'($urandom);
      op = 2'($urandom);
      s_rxr = 2'($urandom); s_rxf = 2'($urandom);
      s_txr = 2'($urandom); s_txe = 2'($urandom);
      rxc = 16'($urandom);
      step(a, op[0], op[1], d, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule